// File: doc/BRIEF.md
# Mode-Dependent Peripheral Clock Gating Controller

This block decides, cycle by cycle, which peripheral clocks may run and which peripherals are held in software reset. It serves twelve peripherals in six groups: four timers, two synchronous serial ports, two UARTs, one I2C controller, two security engines (a cipher engine and a public-key engine) and one radio core. Software keeps three enable sets, one for run mode, one for sleep mode and one for the lightest deep-sleep state. It also keeps one reset set. The power controller reports the current CPU mode, and the block drives the enable set that belongs to that mode onto registered enable outputs. These outputs feed clock gating cells that lie outside the block.

A debugger can force run-mode behaviour through four override inputs. When any override input is high and the chip is not in one of the deeper power modes, the run-mode set drives the enables whatever the reported mode is, and a CPU clock force output goes high. In the deeper power modes the system clock is off, so every enable is driven low and the overrides have no effect.

Registers are written through one write port. A 3-bit group code and a 2-bit kind code select the register, and the low bits of the data word carry one bit per instance of the group.

Top module: `pcg_top`

## Requirements
- R1: While reset is active, and after it is released with no write made, every bit of `clk_en_o`, every bit of `periph_rst_o` and `cpu_clk_force_o` are 0.
- R2: The group codes are timers=0 (4 instances), serial ports=1 (2), UARTs=2 (2), I2C=3 (1), security=4 (2: bit 1 cipher, bit 0 public-key) and radio=5 (1). Data bit i goes to instance i of the group. On both output vectors the groups sit in code order from bit 0 upward: timers 3:0, serial 5:4, UART 7:6, I2C 8, security 10:9, radio 11. Data bits above the group's width are ignored.
- R3: Mode code 00 is run. With no override active, `clk_en_o` equals the run set one clock edge after the mode is presented.
- R4: Mode code 01 is sleep. With no override active, `clk_en_o` equals the sleep set one edge later.
- R5: Mode code 10 is deep-sleep PM0. With no override active, `clk_en_o` equals the deep-sleep set one edge later.
- R6: Mode code 11 is a deeper power mode. `clk_en_o` is all 0 and `cpu_clk_force_o` is 0 one edge later, whatever the override inputs are.
- R7: If any bit of `dbg_ovr` is high in mode 00, 01 or 10, then one edge later `clk_en_o` equals the run set and `cpu_clk_force_o` is 1.
- R8: Kind codes are run=00, sleep=01, deep-sleep=10 and reset=11. A write of kind 11 updates the group's bits of `periph_rst_o` at the write's clock edge. A 1 holds that peripheral in reset and a 0 releases it.
- R9: Writes with group code 6 or 7 change no register. Both output vectors then stay as they were.
- R10: A write and a mode change presented in the same cycle act in this order. At that edge the enables follow the new mode using the old register contents. The written value reaches `clk_en_o` at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_grp | input | 3 | Peripheral group code |
| wr_kind | input | 2 | Register kind: run, sleep, deep-sleep, reset |
| wr_data | input | 4 | Per-instance bit values |
| pwr_mode | input | 2 | Current CPU power mode from the power controller |
| dbg_ovr | input | 4 | Debugger override requests |
| clk_en_o | output | 12 | Per-peripheral clock enables |
| periph_rst_o | output | 12 | Per-peripheral software resets |
| cpu_clk_force_o | output | 1 | CPU clocks forced on by a debugger override |

## Verification
Two functions can fall in the same cycle: a register write and a change of mode or override, which the output stage samples at the same edge. The bench provokes this by presenting a run-set write together with a switch from sleep to run. It checks that the first edge shows the old run contents and the next edge shows the new ones. The bench also sweeps every group code and every kind code, with all data values on the narrow groups, and after each write applies every mode with and without an override. The expected enables come from a bench model built from the group table.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int NUM_GRP = 6;

  // instance count per group, in group-code order
  function automatic int grp_width(input int g);
    case (g)
      0: return 4;   // timers
      1: return 2;   // serial ports
      2: return 2;   // uarts
      3: return 1;   // i2c
      4: return 2;   // security engines
      5: return 1;   // radio core
      default: return 0;
    endcase
  endfunction

  function automatic int grp_base(input int g);
    int b;
    b = 0;
    for (int i = 0; i < g; i++) b += grp_width(i);
    return b;
  endfunction

  localparam int NUM_PERIPH = grp_base(NUM_GRP);

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_DEEP  = 2'b10,
    MODE_OFF   = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    KIND_RUN   = 2'b00,
    KIND_SLEEP = 2'b01,
    KIND_DEEP  = 2'b10,
    KIND_RST   = 2'b11
  } reg_kind_e;

endpackage

// File: rtl/pcg_rst_sync.sv
module pcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pcg_regfile.sv
module pcg_regfile
  import pcg_pkg::*;
#(
  parameter int N      = NUM_PERIPH,
  parameter int DATA_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_grp,
  input  logic [1:0]        wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N-1:0]      run_o,
  output logic [N-1:0]      slp_o,
  output logic [N-1:0]      dps_o,
  output logic [N-1:0]      rst_o
);

  logic [N-1:0] hit;      // flat bit is addressed by this write
  logic [N-1:0] bit_val;  // value routed to each flat bit
  logic [N-1:0] run_q, slp_q, dps_q, rst_q;
  logic [N-1:0] run_d, slp_d, dps_d, rst_d;
  logic         ld_run, ld_slp, ld_dps, ld_rst;

  // route data bits of each group onto its slice of the flat vectors
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int B = grp_base(g);
    localparam int W = grp_width(g);
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign hit[B+b]     = wr_en && (wr_grp == SEL_W'(g));
      assign bit_val[B+b] = wr_data[b];
    end
  end

  assign ld_run = wr_en && (wr_kind == KIND_RUN)   && (|hit);
  assign ld_slp = wr_en && (wr_kind == KIND_SLEEP) && (|hit);
  assign ld_dps = wr_en && (wr_kind == KIND_DEEP)  && (|hit);
  assign ld_rst = wr_en && (wr_kind == KIND_RST)   && (|hit);

  always_comb begin
    run_d = (run_q & ~hit) | (bit_val & hit);
    slp_d = (slp_q & ~hit) | (bit_val & hit);
    dps_d = (dps_q & ~hit) | (bit_val & hit);
    rst_d = (rst_q & ~hit) | (bit_val & hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      slp_q <= '0;
      dps_q <= '0;
      rst_q <= '0;
    end else begin
      if (ld_run) run_q <= run_d;
      if (ld_slp) slp_q <= slp_d;
      if (ld_dps) dps_q <= dps_d;
      if (ld_rst) rst_q <= rst_d;
    end
  end

  assign run_o = run_q;
  assign slp_o = slp_q;
  assign dps_o = dps_q;
  assign rst_o = rst_q;

  // reset writes land in the group's own slice
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    localparam int B = grp_base(g);
    localparam int W = grp_width(g);
    assert_rst_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_grp == SEL_W'(g) && wr_kind == KIND_RST)
      |=> (rst_o[B +: W] == $past(wr_data[W-1:0])));
  end

  assert_bad_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_grp >= SEL_W'(NUM_GRP))
    |=> ($stable(run_o) && $stable(slp_o) && $stable(dps_o) && $stable(rst_o)));

endmodule

// File: rtl/pcg_mode_sel.sv
module pcg_mode_sel
  import pcg_pkg::*;
#(
  parameter int N     = NUM_PERIPH,
  parameter int DBG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [DBG_W-1:0] dbg_i,
  input  logic [N-1:0]     run_i,
  input  logic [N-1:0]     slp_i,
  input  logic [N-1:0]     dps_i,
  output logic [N-1:0]     en_o,
  output logic             cpu_force_o
);

  logic         ovr;
  logic [N-1:0] en_d, en_q;
  logic         force_d, force_q;

  always_comb begin
    ovr     = (|dbg_i) && (mode_i != MODE_OFF);
    force_d = ovr;
    if (ovr) begin
      en_d = run_i;
    end else begin
      case (mode_i)
        MODE_RUN:   en_d = run_i;
        MODE_SLEEP: en_d = slp_i;
        MODE_DEEP:  en_d = dps_i;
        default:    en_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      force_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      force_q <= force_d;
    end
  end

  assign en_o        = en_q;
  assign cpu_force_o = force_q;

  assert_run_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RUN && dbg_i == '0) |=> (en_o == $past(run_i) && !cpu_force_o));

  assert_sleep_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SLEEP && dbg_i == '0) |=> (en_o == $past(slp_i) && !cpu_force_o));

  assert_deep_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_DEEP && dbg_i == '0) |=> (en_o == $past(dps_i) && !cpu_force_o));

  assert_off_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_OFF) |=> (en_o == '0 && !cpu_force_o));

  assert_dbg_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i != '0 && mode_i != MODE_OFF) |=> (en_o == $past(run_i) && cpu_force_o));

endmodule

// File: rtl/pcg_top.sv
module pcg_top
  import pcg_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int SEL_W  = 3,
  parameter int DBG_W  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_grp,
  input  logic [1:0]            wr_kind,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [1:0]            pwr_mode,
  input  logic [DBG_W-1:0]      dbg_ovr,
  output logic [NUM_PERIPH-1:0] clk_en_o,
  output logic [NUM_PERIPH-1:0] periph_rst_o,
  output logic                  cpu_clk_force_o
);

  localparam int N = NUM_PERIPH;

  logic         rst_sync_n;
  logic [N-1:0] run_set, slp_set, dps_set;

  pcg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcg_regfile #(.N(N), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_grp  (wr_grp),
    .wr_kind (wr_kind),
    .wr_data (wr_data),
    .run_o   (run_set),
    .slp_o   (slp_set),
    .dps_o   (dps_set),
    .rst_o   (periph_rst_o)
  );

  pcg_mode_sel #(.N(N), .DBG_W(DBG_W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mode_i      (pwr_mode),
    .dbg_i       (dbg_ovr),
    .run_i       (run_set),
    .slp_i       (slp_set),
    .dps_i       (dps_set),
    .en_o        (clk_en_o),
    .cpu_force_o (cpu_clk_force_o)
  );

  // R1: outputs stay cleared while the synchronised reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    (!rst_sync_n) |=> (clk_en_o == '0 && periph_rst_o == '0 && !cpu_clk_force_o));

endmodule

// File: tb/pcg_top_test.sv
`timescale 1ns/1ps
module pcg_top_test;

  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_grp;
  logic [1:0]    wr_kind;
  logic [3:0]    wr_data;
  logic [1:0]    pwr_mode;
  logic [3:0]    dbg_ovr;
  logic [NP-1:0] clk_en_o, periph_rst_o;
  logic          cpu_clk_force_o;

  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;

  logic [NP-1:0] m_run, m_slp, m_dps, m_rst;
  int gw [6] = '{4, 2, 2, 1, 2, 1};

  always #2.5 clk = ~clk;

  pcg_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp), .wr_kind(wr_kind),
    .wr_data(wr_data), .pwr_mode(pwr_mode), .dbg_ovr(dbg_ovr),
    .clk_en_o(clk_en_o), .periph_rst_o(periph_rst_o), .cpu_clk_force_o(cpu_clk_force_o)
  );

  function automatic int base_of(input int g);
    int s = 0;
    for (int i = 0; i < g; i++) s += gw[i];
    return s;
  endfunction

  task automatic check(input string tag, input logic [NP:0] act, input logic [NP:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected enables from the requirements
  function automatic logic [NP:0] exp_out(input logic [1:0] m, input logic [3:0] d,
                                          input logic [NP-1:0] r, input logic [NP-1:0] s,
                                          input logic [NP-1:0] p);
    if (m == 2'b11)  return '0;
    if (d != 4'h0)   return {1'b1, r};
    case (m)
      2'b00:   return {1'b0, r};
      2'b01:   return {1'b0, s};
      default: return {1'b0, p};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [3:0] d);
    if (m == 2'b11) return "R6";
    if (d != 4'h0)  return "R7";
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic do_write(input int g, input int k, input logic [3:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_grp = 3'(g); wr_kind = 2'(k); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (g < 6) begin
      for (int b = 0; b < gw[g]; b++) begin
        case (k)
          0: m_run[base_of(g)+b] = v[b];
          1: m_slp[base_of(g)+b] = v[b];
          2: m_dps[base_of(g)+b] = v[b];
          default: m_rst[base_of(g)+b] = v[b];
        endcase
      end
    end
    check((g < 6) ? "R2 R8" : "R9", {1'b0, periph_rst_o}, {1'b0, m_rst});
  endtask

  task automatic apply(input logic [1:0] m, input logic [3:0] d);
    @(negedge clk);
    pwr_mode = m; dbg_ovr = d;
    @(negedge clk);
    check(tag_of(m, d), {cpu_clk_force_o, clk_en_o}, exp_out(m, d, m_run, m_slp, m_dps));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_grp = '0; wr_kind = '0; wr_data = '0;
    pwr_mode = 2'b00; dbg_ovr = 4'h0;
    m_run = '0; m_slp = '0; m_dps = '0; m_rst = '0;
    repeat (3) @(negedge clk);
    check("R1", {cpu_clk_force_o, clk_en_o}, '0);
    check("R1", {1'b0, periph_rst_o}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {cpu_clk_force_o, clk_en_o}, '0);
    check("R1", {1'b0, periph_rst_o}, '0);

    // sweep all group codes, kinds and data values
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 4; k++) begin
        for (int v = 0; v < 16; v++) begin
          do_write(g, k, 4'(v ^ (g * 5) ^ k));
          for (int m = 0; m < 4; m++) begin
            apply(2'(m), 4'h0);
            apply(2'(m), 4'(1 << ((v + m) % 4)));
          end
        end
      end
    end

    // every override pattern in every mode
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 16; d++)
        apply(2'(m), 4'(d));

    // R10: write and mode change in the same cycle
    do_write(0, 0, 4'h3);
    apply(2'b01, 4'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_grp = 3'd0; wr_kind = 2'd0; wr_data = 4'hC; pwr_mode = 2'b00;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10", {cpu_clk_force_o, clk_en_o}, {1'b0, m_run});
    m_run[3:0] = 4'hC;
    @(negedge clk);
    check("R10", {cpu_clk_force_o, clk_en_o}, {1'b0, m_run});

    // R1: reset reasserted clears everything
    do_write(2, 3, 4'h3);
    apply(2'b00, 4'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {cpu_clk_force_o, clk_en_o}, '0);
    check("R1", {1'b0, periph_rst_o}, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule